// File: doc/BRIEF.md
# Single-Wire Configuration Register Target

This block is the device-side loader for a 15-bit configuration register that is written over one shared data line. The line is open-drain and pulled up. The host and the device both pull it low and never drive it high. A session starts when the host holds the line low for a long start period. After the host releases the line, the device sets all the timing. It waits a fixed delay, then opens 15 bit slots in turn, and it marks the start of each slot with a short low synchronization pulse of its own.

Inside each slot, a sampling window opens a fixed time after the synchronization pulse. If the host pulls the line low for long enough inside that window, the bit for that slot is written as zero. If the host does nothing, the bit is written as one. All values are gathered in a shadow register. The visible register changes only when the fifteenth slot ends, and a one-cycle done strobe marks that change. Every timing value is a parameter, counted in clock cycles.

Top module: `cfgwire_target`

## Requirements
- R1: During reset and after it: the register output is all ones, the line drive enable is high (line released), busy is 0 and done is 0.
- R2: While idle, the synchronized line must stay low for T_START consecutive cycles before a session starts and busy goes to 1. A shorter low level has no effect.
- R3: After the host releases the line, the first synchronization pulse starts T_DELAY+3 cycles later, measured at the pins. This count includes the 2-flop synchronizer and the release-detection register. The device then drives exactly 15 low pulses. Each pulse lasts T_SYNC cycles, and each starts T_SLOT cycles after the previous one.
- R4: Slot cycle positions are counted from the start of the slot's synchronization pulse. If the synchronized line is low for at least T_PMIN consecutive cycles at positions T_SYNC+T_WOFS through T_SYNC+T_WOFS+T_WLEN-1, that slot's bit is stored as 0. Otherwise it is stored as 1.
- R5: A low pulse shorter than T_PMIN cycles inside the window leaves the bit at 1.
- R6: A low level that lies entirely outside the window, after the window closes and before the next slot, leaves the bit at 1.
- R7: Slot k, counted from 0, writes register bit k. The first slot (the start bit) writes bit 0 and the fifteenth slot (the stop bit) writes bit 14.
- R8: During a session the register output keeps its previous value. All 15 bits change together in the cycle when done is 1, and done is 1 for exactly one cycle per session.
- R9: busy stays 1 from start detection until done. During a session, a low level longer than T_START does not restart the session or change the slot count. After done, the block is idle until a new start request arrives.
- R10: The line drive enable goes low only during synchronization pulses, and only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Level of the shared data line, asynchronous |
| line_drv_n_o | output | 1 | Active-low open-drain drive enable; 0 pulls the line low |
| cfg_o | output | 15 | Configuration register; bit k is written in slot k |
| done_o | output | 1 | One-cycle strobe when the register updates |
| busy_o | output | 1 | High while a session is in progress |

## Verification
Two functions can act in the same cycle: start detection and bit sampling. This happens when the host holds the line low inside a slot for longer than the start period. The bench provokes it with a "long hold" slot, where the host stays low across most of the slot. It then judges the result by three checks: the slot's bit reads 0, exactly 15 synchronization pulses and one done strobe occur, and the block stays idle after done. The same logic applies to the window sampler and the block's own synchronization pulse, which share the line in every slot. Lows placed just after the window and short glitches inside it confirm that only a qualified pulse inside the window clears a bit.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_DELAY,
        ST_SLOT
    } cfgw_state_e;

    typedef struct packed {
        logic sync_on;
        logic win_on;
        logic slot_end;
    } slot_pos_t;

    function automatic int cnt_width(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgw_sync.sv
module cfgw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgw_start_det.sv
module cfgw_start_det
    import cfgw_pkg::*;
#(
    parameter int T_START = 36
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic line_lo,
    output logic hit
);
    localparam int CW = cnt_width(T_START);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !enable || !line_lo) run <= '0;
        else if (run != CW'(T_START - 1)) run <= run + 1'b1;
    end

    assign hit = enable && line_lo && (run == CW'(T_START - 1));
endmodule

// File: rtl/cfgw_bit_sampler.sv
module cfgw_bit_sampler
    import cfgw_pkg::*;
#(
    parameter int T_PMIN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic win,
    input  logic line_lo,
    output logic zero_seen
);
    localparam int CW = cnt_width(T_PMIN);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run       <= '0;
            zero_seen <= 1'b0;
        end else if (win && line_lo) begin
            if (run == CW'(T_PMIN - 1)) zero_seen <= 1'b1;
            if (run != CW'(T_PMIN))     run <= run + 1'b1;
        end else begin
            run <= '0;
        end
    end
endmodule

// File: rtl/cfgwire_target.sv
module cfgwire_target
    import cfgw_pkg::*;
#(
    parameter int NBITS   = 15,
    parameter int T_START = 36,
    parameter int T_DELAY = 20,
    parameter int T_SYNC  = 8,
    parameter int T_WOFS  = 12,
    parameter int T_WLEN  = 30,
    parameter int T_SLOT  = 64,
    parameter int T_PMIN  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    output logic             line_drv_n_o,
    output logic [NBITS-1:0] cfg_o,
    output logic             done_o,
    output logic             busy_o
);
    localparam int CW     = cnt_width(max2(T_DELAY, T_SLOT));
    localparam int IW     = cnt_width(NBITS);
    localparam int WIN_LO = T_SYNC + T_WOFS;
    localparam int WIN_HI = T_SYNC + T_WOFS + T_WLEN;

    cfgw_state_e      state;
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    idx;
    logic [NBITS-1:0] shadow, shadow_nx;
    logic             line_s, start_hit, zero_seen;
    slot_pos_t        pos;

    cfgw_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(line_i), .q(line_s)
    );

    cfgw_start_det #(.T_START(T_START)) u_start (
        .clk(clk), .rst(rst), .enable(state == ST_IDLE),
        .line_lo(!line_s), .hit(start_hit)
    );

    cfgw_bit_sampler #(.T_PMIN(T_PMIN)) u_samp (
        .clk(clk), .rst(rst),
        .clear((state != ST_SLOT) || pos.slot_end),
        .win(pos.win_on), .line_lo(!line_s), .zero_seen(zero_seen)
    );

    always_comb begin
        pos.sync_on  = (state == ST_SLOT) && (cnt < CW'(T_SYNC));
        pos.win_on   = (state == ST_SLOT) && (cnt >= CW'(WIN_LO)) && (cnt < CW'(WIN_HI));
        pos.slot_end = (state == ST_SLOT) && (cnt == CW'(T_SLOT - 1));
    end

    always_comb begin
        shadow_nx      = shadow;
        shadow_nx[idx] = !zero_seen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shadow <= '1;
            cfg_o  <= '1;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_hit) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (line_s) begin
                        state <= ST_DELAY;
                        cnt   <= '0;
                    end
                end
                ST_DELAY: begin
                    if (cnt == CW'(T_DELAY - 1)) begin
                        state <= ST_SLOT;
                        cnt   <= '0;
                        idx   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SLOT: begin
                    if (pos.slot_end) begin
                        cnt    <= '0;
                        shadow <= shadow_nx;
                        if (idx == IW'(NBITS - 1)) begin
                            cfg_o  <= shadow_nx;
                            done_o <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign line_drv_n_o = !pos.sync_on;
    assign busy_o       = (state != ST_IDLE);
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker #(
    parameter int NBITS = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             line_i,
    input logic             line_drv_n_o,
    input logic [NBITS-1:0] cfg_o,
    input logic             done_o,
    input logic             busy_o
);
    a_r10_drive_only_busy: assert property (@(posedge clk) disable iff (rst)
        !line_drv_n_o |-> busy_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_cfg_held: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(cfg_o));

    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    a_r2_start_needs_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(line_i, 2) == 1'b0));

    a_r3_sync_not_single: assert property (@(posedge clk) disable iff (rst)
        $fell(line_drv_n_o) |=> !line_drv_n_o);

    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (line_drv_n_o && !done_o && !busy_o));
endmodule

bind cfgwire_target cfgw_checker #(.NBITS(NBITS)) u_chk (
    .clk(clk), .rst(rst), .line_i(line_i), .line_drv_n_o(line_drv_n_o),
    .cfg_o(cfg_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/cfgwire_target_test.sv
module cfgwire_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int NBITS   = 15;
    localparam int T_START = 36;
    localparam int T_DELAY = 20;
    localparam int T_SYNC  = 8;
    localparam int T_WOFS  = 12;
    localparam int T_WLEN  = 30;
    localparam int T_SLOT  = 64;
    localparam int T_PMIN  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_low = 1'b0;
    logic line_i;
    logic line_drv_n_o, done_o, busy_o;
    logic [NBITS-1:0] cfg_o;

    assign line_i = !(host_low || !line_drv_n_o);

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgwire_target #(
        .NBITS(NBITS), .T_START(T_START), .T_DELAY(T_DELAY), .T_SYNC(T_SYNC),
        .T_WOFS(T_WOFS), .T_WLEN(T_WLEN), .T_SLOT(T_SLOT), .T_PMIN(T_PMIN)
    ) uut (
        .clk(clk), .rst(rst), .line_i(line_i), .line_drv_n_o(line_drv_n_o),
        .cfg_o(cfg_o), .done_o(done_o), .busy_o(busy_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int modes [NBITS];
    logic [NBITS-1:0] model_cfg;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sync pulse monitor: width and spacing (R3)
    bit mon_en = 1'b0;
    int falls = 0;
    int since_fall = 0;
    int low_run = 0;
    logic drv_prev = 1'b1;

    always @(negedge clk) begin
        if (mon_en) begin
            since_fall++;
            if (drv_prev && !line_drv_n_o) begin
                if (falls > 0) chk(since_fall == T_SLOT, "R3 sync spacing", since_fall, T_SLOT);
                falls++;
                since_fall = 0;
                low_run = 1;
            end else if (!line_drv_n_o) begin
                low_run++;
            end else if (!drv_prev) begin
                chk(low_run == T_SYNC, "R3 sync width", low_run, T_SYNC);
            end
        end
        drv_prev = line_drv_n_o;
    end

    // mode: 0 none, 1 valid pulse, 2 glitch, 3 after window, 4 long hold
    function automatic logic exp_bit(input int m);
        return (m == 1 || m == 4) ? 1'b0 : 1'b1;
    endfunction

    task automatic hold_low(input int len);
        host_low = 1'b1;
        repeat (len) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic session;
        logic [NBITS-1:0] expv;
        int k;
        int dones;
        falls = 0;
        since_fall = 0;
        mon_en = 1'b1;
        @(negedge clk);
        hold_low(T_START + 5);
        chk(busy_o == 1'b1, "R2 start accepted", busy_o, 1);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (line_drv_n_o && k < 500);
        chk(k == T_DELAY + 3, "R3 release to first sync", k, T_DELAY + 3);
        for (int i = 0; i < NBITS; i++) begin
            if (i > 0) begin
                k = 0;
                while (line_drv_n_o && k < 500) begin
                    @(negedge clk);
                    k++;
                end
            end
            expv[i] = exp_bit(modes[i]);
            if (i == 7) chk(cfg_o == model_cfg, "R8 held mid-session", cfg_o, model_cfg);
            repeat (T_SYNC + T_WOFS + 2) @(negedge clk);
            case (modes[i])
                1: hold_low(T_PMIN + int'($urandom_range(0, 14)));
                2: hold_low(int'($urandom_range(1, T_PMIN - 1)));
                3: begin
                    repeat (T_WLEN + 2) @(negedge clk);
                    hold_low(T_PMIN);
                end
                4: hold_low(T_START + 4);
                default: ;
            endcase
        end
        dones = 0;
        for (int j = 0; j < 120; j++) begin
            @(negedge clk);
            if (done_o) begin
                dones++;
                chk(cfg_o == expv, "R4 R5 R6 R7 register value", cfg_o, expv);
            end
        end
        chk(dones == 1, "R8 done count", dones, 1);
        chk(falls == NBITS, "R3 R9 sync pulse count", falls, NBITS);
        chk(busy_o == 1'b0, "R9 idle after done", busy_o, 0);
        mon_en = 1'b0;
        model_cfg = expv;
        k = 0;
        for (int j = 0; j < 60; j++) begin
            @(negedge clk);
            if (busy_o) k++;
        end
        chk(k == 0, "R9 no restart", k, 0);
    endtask

    task automatic short_start;
        int seen = 0;
        @(negedge clk);
        hold_low(T_START - 8);
        for (int j = 0; j < 80; j++) begin
            @(negedge clk);
            if (busy_o) seen++;
        end
        chk(seen == 0, "R2 short low ignored", seen, 0);
        chk(cfg_o == model_cfg, "R2 register untouched", cfg_o, model_cfg);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        model_cfg = '1;
        repeat (4) @(negedge clk);
        chk(cfg_o == '1, "R1 reset register", cfg_o, 16'h7fff);
        chk(line_drv_n_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R1 reset outputs",
            {line_drv_n_o, busy_o, done_o}, 3'b100);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(cfg_o == '1 && busy_o == 1'b0, "R1 after reset", cfg_o, 16'h7fff);

        short_start();

        // all zeros (R7 first/last bit included)
        for (int i = 0; i < NBITS; i++) modes[i] = 1;
        session();
        // nothing driven: all ones
        for (int i = 0; i < NBITS; i++) modes[i] = 0;
        session();
        // start bit and stop bit only (R7), glitch and after-window lows elsewhere
        for (int i = 0; i < NBITS; i++) modes[i] = (i % 2 == 0) ? 2 : 3;
        modes[0] = 1;
        modes[NBITS-1] = 1;
        session();
        // long hold inside a session (R9)
        for (int i = 0; i < NBITS; i++) modes[i] = 0;
        modes[3] = 4;
        modes[NBITS-1] = 4;
        session();

        short_start();

        for (int s = 0; s < 5; s++) begin
            for (int i = 0; i < NBITS; i++) begin
                int r;
                r = int'($urandom_range(0, 99));
                modes[i] = (r < 40) ? 0 : (r < 75) ? 1 : (r < 85) ? 2 : (r < 95) ? 3 : 4;
            end
            session();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule